// File: doc/BRIEF.md
# DMA Fault Interrupt Gate

This block gathers fault and event conditions raised by a DMA instruction engine into a status register. It routes them through a per-bit enable register onto a latched, active-low interrupt request. There are six event inputs: master data parity error, bus fault, abort, single-step, script interrupt instruction and illegal instruction. Each one is a single-cycle pulse.

A small CPU register port writes the enable register and reads back either the enable register or the status register. Reading the status register clears it. The enable bits only gate the interrupt pin. A disabled condition still records its status bit and still raises the pending summary output. Every condition is fatal, so any event halts the engine whether it is enabled or not. The halt stays in force until software has read the status and issued a restart pulse.

Top module: `dma_irq_mask_ctrl`

## Requirements
- R1: After reset the enable register and the status register read 0x00, irq_n is 1, dma_pend is 0 and halt is 0.
- R2: The enable register and the status register share one bit layout: bit 6 parity error, bit 5 bus fault, bit 4 abort, bit 3 single-step, bit 2 script interrupt, bit 0 illegal instruction. A write with cpu_sel=0 loads the enable register. A read with cpu_sel=0 returns the enable register and a read with cpu_sel=1 returns the status register.
- R3: An event pulse sets its status bit in the clock edge that samples the pulse, whatever the enable register holds. dma_pend is the OR of all status bits.
- R4: irq_n goes low on the clock edge after a status bit and its enable bit are both 1. A status bit whose enable bit is 0 never pulls irq_n low.
- R5: A disabled condition that is pending does not stop a later enabled condition from driving irq_n low.
- R6: Once irq_n is low it stays low, even if the enable register is cleared afterwards. It returns high at the edge that completes a status read.
- R7: halt goes high at the clock edge that samples any event pulse, whether that event is enabled or disabled.
- R8: halt clears only at a clock edge where restart is 1 and the status register is already zero. A restart pulse given while status bits are set is ignored.
- R9: A status read returns the current bits combinationally and clears them at the next edge. An event sampled at that same edge stays set.
- R10: Bits 7 and 1 always read as 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_parity | input | 1 | Master data parity error pulse |
| ev_busfault | input | 1 | Bus fault pulse |
| ev_abort | input | 1 | Abort pulse |
| ev_step | input | 1 | Single-step pulse |
| ev_script | input | 1 | Script interrupt instruction pulse |
| ev_illegal | input | 1 | Illegal instruction pulse |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe |
| cpu_sel | input | 1 | 0 selects enable, 1 selects status |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, combinational |
| restart | input | 1 | Engine restart pulse |
| irq_n | output | 1 | Latched interrupt request, active low |
| dma_pend | output | 1 | Any status bit set |
| halt | output | 1 | Engine halt request |

## Verification
The first edge after an event pulse updates the status bits, dma_pend and halt. Read data is valid in the same cycle as the read strobe. irq_n responds one edge after the enabling status bit, which is two edges after the pulse. A read releases irq_n at the edge that ends the read. The bench changes its inputs just after a rising edge and samples at the following falling edge. It counts edges explicitly, so it checks that irq_n is still high in the cycle before it is due to fall. A read driver pushes the expected read data into a queue, and a monitor pops that value and compares it on every cycle that carries a read strobe.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
  localparam int REG_W     = 8;
  localparam int B_PARITY  = 6;
  localparam int B_BUSFLT  = 5;
  localparam int B_ABORT   = 4;
  localparam int B_STEP    = 3;
  localparam int B_SCRIPT  = 2;
  localparam int B_ILLEGAL = 0;
  localparam logic [REG_W-1:0] VALID_MASK =
    REG_W'((1 << B_PARITY) | (1 << B_BUSFLT) | (1 << B_ABORT) |
           (1 << B_STEP) | (1 << B_SCRIPT) | (1 << B_ILLEGAL));

  typedef enum logic {
    SEL_ENABLE = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/dmairq_status.sv
module dmairq_status #(
  parameter int W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev_vec,
  input  logic         rd_clr,
  output logic [W-1:0] status
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (VALID[i]) begin : g_live
      logic bit_d, bit_q;
      always_comb begin
        bit_d = ev_vec[i] | (bit_q & ~rd_clr);
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bit_q <= 1'b0;
        else        bit_q <= bit_d;
      end
      assign status[i] = bit_q;
    end else begin : g_rsvd
      assign status[i] = 1'b0;
    end
  end

  // R3: any valid event is recorded at the next edge
  a_r3_event_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    (|(ev_vec & VALID)) |=> (|status));
  // R9: event coinciding with a clearing read survives
  a_r9_read_keeps_event: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (|(ev_vec & VALID))) |=> (|status));
  // R9: read without events leaves status empty
  a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !(|(ev_vec & VALID))) |=> (status == '0));
endmodule

// File: rtl/dmairq_enable.sv
module dmairq_enable #(
  parameter int W = 8,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] enable
);
  logic [W-1:0] en_d, en_q;

  always_comb begin
    en_d = en_q;
    if (wr_en) en_d = wdata & VALID;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign enable = en_q;

  // R2: a write is reflected at the next edge
  a_r2_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (enable == ($past(wdata) & VALID)));
endmodule

// File: rtl/dmairq_irq_latch.sv
module dmairq_irq_latch #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] status,
  input  logic [W-1:0] enable,
  input  logic         rd_clr,
  output logic         irq_n
);
  logic irq_d, irq_q;
  logic hit;

  always_comb begin
    hit   = |(status & enable);
    irq_d = irq_q | hit;
    if (rd_clr) irq_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_n = ~irq_q;

  // R4: enabled pending condition raises the request next edge
  a_r4_irq_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !rd_clr) |=> !irq_n);
  // R6: request held until a status read
  a_r6_irq_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !rd_clr) |=> !irq_n);
  // R6: release only follows a read
  a_r6_irq_release: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_n) |-> $past(rd_clr));
endmodule

// File: rtl/dmairq_halt.sv
module dmairq_halt (
  input  logic clk,
  input  logic rst_n,
  input  logic any_ev,
  input  logic restart,
  input  logic status_zero,
  output logic halt
);
  logic halt_d, halt_q;

  always_comb begin
    halt_d = halt_q;
    if (restart && status_zero) halt_d = 1'b0;
    if (any_ev)                 halt_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b0;
    else        halt_q <= halt_d;
  end

  assign halt = halt_q;

  // R7: any event halts the engine
  a_r7_event_halts: assert property (@(posedge clk) disable iff (!rst_n)
    any_ev |=> halt);
  // R8: halt drops only after restart with status empty
  a_r8_halt_release: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halt) |-> ($past(restart) && $past(status_zero)));
endmodule

// File: rtl/dma_irq_mask_ctrl.sv
module dma_irq_mask_ctrl
  import dmairq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_parity,
  input  logic             ev_busfault,
  input  logic             ev_abort,
  input  logic             ev_step,
  input  logic             ev_script,
  input  logic             ev_illegal,
  input  logic             cpu_wr,
  input  logic             cpu_rd,
  input  logic             cpu_sel,
  input  logic [REG_W-1:0] cpu_wdata,
  output logic [REG_W-1:0] cpu_rdata,
  input  logic             restart,
  output logic             irq_n,
  output logic             dma_pend,
  output logic             halt
);
  localparam int W = REG_W;
  localparam logic [W-1:0] VALID = VALID_MASK;

  logic [W-1:0] ev_vec, status, enable;
  logic         rd_clr, en_wr;
  reg_sel_e     sel;

  always_comb begin
    ev_vec            = '0;
    ev_vec[B_PARITY]  = ev_parity;
    ev_vec[B_BUSFLT]  = ev_busfault;
    ev_vec[B_ABORT]   = ev_abort;
    ev_vec[B_STEP]    = ev_step;
    ev_vec[B_SCRIPT]  = ev_script;
    ev_vec[B_ILLEGAL] = ev_illegal;
  end

  assign sel    = reg_sel_e'(cpu_sel);
  assign rd_clr = cpu_rd && (sel == SEL_STATUS);
  assign en_wr  = cpu_wr && (sel == SEL_ENABLE);

  dmairq_status #(.W(W), .VALID(VALID)) u_status (
    .clk(clk), .rst_n(rst_n), .ev_vec(ev_vec), .rd_clr(rd_clr), .status(status)
  );

  dmairq_enable #(.W(W), .VALID(VALID)) u_enable (
    .clk(clk), .rst_n(rst_n), .wr_en(en_wr), .wdata(cpu_wdata), .enable(enable)
  );

  dmairq_irq_latch #(.W(W)) u_irq (
    .clk(clk), .rst_n(rst_n), .status(status), .enable(enable),
    .rd_clr(rd_clr), .irq_n(irq_n)
  );

  dmairq_halt u_halt (
    .clk(clk), .rst_n(rst_n), .any_ev(|ev_vec), .restart(restart),
    .status_zero(status == '0), .halt(halt)
  );

  always_comb begin
    cpu_rdata = (sel == SEL_STATUS) ? status : enable;
    cpu_rdata = cpu_rdata & VALID;
  end

  assign dma_pend = |status;

  // R10: reserved positions never read as 1
  a_r10_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rd |-> ((cpu_rdata & ~VALID) == '0));
  // R3: pending summary follows a recorded event
  a_r3_pend_after_event: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_vec) |=> dma_pend);
endmodule

// File: tb/dma_irq_mask_ctrl_bench.sv
module dma_irq_mask_ctrl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_parity = 0, ev_busfault = 0, ev_abort = 0, ev_step = 0, ev_script = 0, ev_illegal = 0;
  logic cpu_wr = 0, cpu_rd = 0, cpu_sel = 0, restart = 0;
  logic [7:0] cpu_wdata = 8'h00;
  logic [7:0] cpu_rdata;
  logic irq_n, dma_pend, halt;

  int applied = 0;
  int miscomp = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #10 clk = ~clk;

  dma_irq_mask_ctrl u_dma_irq_mask_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ev_parity(ev_parity), .ev_busfault(ev_busfault), .ev_abort(ev_abort),
    .ev_step(ev_step), .ev_script(ev_script), .ev_illegal(ev_illegal),
    .cpu_wr(cpu_wr), .cpu_rd(cpu_rd), .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .restart(restart),
    .irq_n(irq_n), .dma_pend(dma_pend), .halt(halt)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    applied++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (cpu_rd) begin
      if (exp_q.size() == 0) begin
        chk("scoreboard-empty", 8'h00, 8'hFF);
      end else begin
        chk(tag_q.pop_front(), cpu_rdata, exp_q.pop_front());
      end
    end
  end

  task automatic set_ev(logic [7:0] v);
    ev_parity = v[6]; ev_busfault = v[5]; ev_abort = v[4];
    ev_step = v[3]; ev_script = v[2]; ev_illegal = v[0];
  endtask

  task automatic pulse(logic [7:0] v);
    @(posedge clk); #1 set_ev(v);
    @(posedge clk); #1 set_ev(8'h00);
  endtask

  task automatic wr_en(logic [7:0] d);
    @(posedge clk); #1 cpu_wr = 1; cpu_sel = 0; cpu_wdata = d;
    @(posedge clk); #1 cpu_wr = 0;
  endtask

  task automatic rd(logic sel, logic [7:0] exp, string req);
    @(posedge clk); #1 cpu_rd = 1; cpu_sel = sel;
    exp_q.push_back(exp); tag_q.push_back(req);
    @(posedge clk); #1 cpu_rd = 0;
  endtask

  task automatic do_restart();
    @(posedge clk); #1 restart = 1;
    @(posedge clk); #1 restart = 0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
    chk("R1 dma_pend", {7'd0, dma_pend}, 8'h00);
    chk("R1 halt", {7'd0, halt}, 8'h00);
    rd(0, 8'h00, "R1 enable reset");
    rd(1, 8'h00, "R1 status reset");

    // R2 / R10: reserved write bits dropped
    wr_en(8'hFF);
    rd(0, 8'h7D, "R10 reserved masked");
    wr_en(8'h00);

    // R3 / R4 / R7: disabled parity event
    pulse(8'h40);
    @(negedge clk);
    chk("R3 dma_pend", {7'd0, dma_pend}, 8'h01);
    chk("R7 halt", {7'd0, halt}, 8'h01);
    @(posedge clk); @(negedge clk);
    chk("R4 masked no irq", {7'd0, irq_n}, 8'h01);
    do_restart();
    @(negedge clk);
    chk("R8 restart ignored", {7'd0, halt}, 8'h01);
    rd(1, 8'h40, "R3 status parity bit6");
    @(negedge clk);
    chk("R9 cleared pend", {7'd0, dma_pend}, 8'h00);
    chk("R8 halt held after read", {7'd0, halt}, 8'h01);
    do_restart();
    @(negedge clk);
    chk("R8 halt released", {7'd0, halt}, 8'h00);

    // R5 / R6: masked bus fault, then enabled illegal
    wr_en(8'h01);
    pulse(8'h20);
    @(posedge clk); @(negedge clk);
    chk("R4 busfault masked", {7'd0, irq_n}, 8'h01);
    pulse(8'h01);
    @(negedge clk);
    chk("R4 irq not yet", {7'd0, irq_n}, 8'h01);
    @(posedge clk); @(negedge clk);
    chk("R5 irq low", {7'd0, irq_n}, 8'h00);
    wr_en(8'h00);
    @(negedge clk);
    chk("R6 latched after unmask", {7'd0, irq_n}, 8'h00);
    rd(1, 8'h21, "R2 status layout bits5,0");
    @(negedge clk);
    chk("R6 released", {7'd0, irq_n}, 8'h01);
    do_restart();

    // R9: event coinciding with status read
    wr_en(8'h04);
    pulse(8'h10);
    @(posedge clk); #1 cpu_rd = 1; cpu_sel = 1; set_ev(8'h04);
    exp_q.push_back(8'h10); tag_q.push_back("R9 read value");
    @(posedge clk); #1 cpu_rd = 0; set_ev(8'h00);
    @(posedge clk); @(negedge clk);
    chk("R9 event kept irq", {7'd0, irq_n}, 8'h00);
    rd(1, 8'h04, "R9 event kept status");
    rd(1, 8'h08 & 8'h00, "R9 empty after read");
    do_restart();
    @(negedge clk);
    chk("R8 final halt", {7'd0, halt}, 8'h00);
    chk("R1 queue drained", 8'(exp_q.size()), 8'h00);

    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    applied++; miscomp++;
    $display("FAIL watchdog R1: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", applied, miscomp);
    $finish;
  end
endmodule